// File: doc/BRIEF.md
# Quasi-Random Test Pattern Source with Error and Violation Insertion

This block produces a pseudo-random test bit stream for a T1 line transmitter. A 20-stage linear feedback shift register supplies the base sequence. A zero-run guard forces a one into any position that would otherwise extend a run of zeros beyond fourteen. The stream leaves the block as a unipolar data bit and as a pair of alternate-mark-inversion rails, so line-code faults are visible at the output.

Two request inputs let a test operator or a bench controller corrupt the stream in a controlled way. A rising edge on the logic-error request inverts exactly one transmitted bit. A rising edge on the violation request makes the next mark repeat the polarity of the previous mark. Both requests are synchronised to the transmit clock and held as pending until they are used. A two-bit pattern select turns the source on only for one code. In every other code the outputs rest at zero and all pattern state is frozen.

Top module: `qrss_gen`

## Requirements
- R1: The source runs only while `pat_sel` equals 2'b10 (bit 1 set, bit 0 clear). For any other value, `tx_bit`, `tx_pos` and `tx_neg` are 0 one clock after that value is sampled.
- R2: While the source is off, the register sequence, the zero-run count, the mark polarity and any pending requests keep their values. When it is turned back on, the stream resumes exactly where it stopped.
- R3: The base sequence comes from a 20-bit register reset to 20'h00001. Each enabled clock transmits bit 19 and shifts left, with bit 19 XOR bit 16 entering at bit 0 (polynomial x^20 + x^17 + 1).
- R4: When fourteen zeros have just been sent, the next transmitted bit is forced to 1. No run of zeros in the enabled stream is longer than fourteen.
- R5: A rising edge on `err_req` inverts exactly one transmitted bit. After two synchroniser stages and an edge detector, the request is pending from the third clock edge after it is sampled high, and it applies to the next enabled bit. A level held low inserts nothing.
- R6: A pending error that meets a forced (jammed) bit is not applied there. It stays pending and inverts the following enabled bit.
- R7: Each request line produces at most one insertion per rising edge. A rising edge that arrives while the same kind of request is still pending is discarded, and holding a request high produces a single insertion.
- R8: Marks (transmitted ones) alternate between `tx_pos` and `tx_neg`, starting with `tx_pos` after reset. A pending violation makes the next mark take the same rail as the previous mark, and alternation then continues from that rail. Spaces drive both rails low.
- R9: Violation insertion acts on the rails in both output modes (`uni_mode` 0 or 1).
- R10: With `uni_mode` = 1, `tx_bit` carries the transmitted bit. With `uni_mode` = 0, `tx_bit` is held at 0 and the data is carried only on the rails.
- R11: A synchronous active-high `rst` clears all three outputs, loads the register seed, clears the zero-run count and pending requests, and sets the mark polarity so the first mark goes to `tx_pos`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_sel | input | 2 | Pattern select; 2'b10 enables the source |
| uni_mode | input | 1 | 1 = unipolar data on `tx_bit`; 0 = rails only |
| err_req | input | 1 | Logic-error request, asynchronous, acted on at its rising edge |
| bpv_req | input | 1 | Violation request, asynchronous, acted on at its rising edge |
| tx_bit | output | 1 | Registered unipolar data bit |
| tx_pos | output | 1 | Registered positive rail |
| tx_neg | output | 1 | Registered negative rail |

## Verification
A corrupted shift register shows up within one enabled clock as a wrong output bit, because the bench tracks the full 20-bit sequence. A zero-run count that is off by one moves the forced one, which breaks the sequence on the very next bit. A lost or duplicated pending request shows as a missing or extra inverted bit, or a missing or extra same-polarity mark pair, a few clocks after the request edge. A wrong stored polarity makes the next mark land on the wrong rail. The bench also runs an independent observer on the rails that counts same-polarity mark pairs, and it compares that count with the number of violations requested.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

    localparam int          LFSR_W    = 20;
    localparam int          TAP_HI    = 19;
    localparam int          TAP_LO    = 16;
    localparam logic [1:0]  PSEL_QRSS = 2'b10;

    typedef struct packed {
        logic data;
        logic pos;
        logic neg;
    } line_sym_t;

    function automatic logic sel_is_qrss(input logic [1:0] sel);
        return (sel == PSEL_QRSS);
    endfunction

    function automatic logic ami_polarity(input logic last_pos, input logic viol);
        return viol ? last_pos : ~last_pos;
    endfunction

endpackage

// File: rtl/qrss_lfsr.sv
module qrss_lfsr #(
    parameter int             W      = qrss_pkg::LFSR_W,
    parameter int             T_HI   = qrss_pkg::TAP_HI,
    parameter int             T_LO   = qrss_pkg::TAP_LO,
    parameter logic [W-1:0]   SEED   = {{(W-1){1'b0}}, 1'b1}
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic msb
);
    logic [W-1:0] state_q;
    logic         fb;

    assign fb  = state_q[T_HI] ^ state_q[T_LO];
    assign msb = state_q[W-1];

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (adv)
            state_q <= {state_q[W-2:0], fb};
    end

    // R2: sequence state frozen while the source is off
    a_r2_lfsr_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q));

    // R3: the register never falls into the all-zero lock-up state
    a_r3_lfsr_live: assert property (@(posedge clk) disable iff (rst)
        adv |=> (state_q != '0));
endmodule

// File: rtl/qrss_zero_guard.sv
module qrss_zero_guard #(
    parameter int MAX_ZEROS = 14,
    localparam int CW       = $clog2(MAX_ZEROS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic sent_bit,
    output logic jam
);
    logic [CW-1:0] run_q;

    assign jam = (run_q == CW'(MAX_ZEROS));

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (adv)
            run_q <= sent_bit ? '0 : run_q + 1'b1;
    end

    // R4: the run count never passes the limit
    a_r4_run_bound: assert property (@(posedge clk) disable iff (rst)
        run_q <= CW'(MAX_ZEROS));

    // R2: count frozen while the source is off
    a_r2_run_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(run_q));
endmodule

// File: rtl/qrss_req_sync.sv
module qrss_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    input  logic consume,
    output logic pend
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= req_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign rise = sync_q[STAGES-1] & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= sync_q[STAGES-1];
            pend   <= (pend & ~consume) | (rise & ~pend);
        end
    end

    // R7: a pending request survives until it is used
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (rst)
        (pend && !consume) |=> pend);

    // R7: a used request is gone, and an edge during use is discarded
    a_r7_pend_used: assert property (@(posedge clk) disable iff (rst)
        (pend && consume) |=> !pend);
endmodule

// File: rtl/qrss_ami_enc.sv
module qrss_ami_enc
    import qrss_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  logic      mark,
    input  logic      viol,
    input  logic      uni_mode,
    output line_sym_t sym
);
    logic last_pos_q;
    logic pol;

    assign pol = ami_polarity(last_pos_q, viol);

    always_ff @(posedge clk) begin
        if (rst) begin
            sym        <= '0;
            last_pos_q <= 1'b0;
        end else if (adv) begin
            sym.data <= uni_mode & mark;
            sym.pos  <= mark & pol;
            sym.neg  <= mark & ~pol;
            if (mark)
                last_pos_q <= pol;
        end else begin
            sym <= '0;
        end
    end

    // R8: ordinary marks alternate rails
    a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
        (adv && mark && !viol) |=> (sym.pos == !$past(last_pos_q)) && (sym.pos != sym.neg));

    // R8: a violation repeats the previous rail
    a_r8_repeat: assert property (@(posedge clk) disable iff (rst)
        (adv && mark && viol) |=> (sym.pos == $past(last_pos_q)) && (sym.pos != sym.neg));

    // R8: spaces drive no rail
    a_r8_space: assert property (@(posedge clk) disable iff (rst)
        (adv && !mark) |=> !sym.pos && !sym.neg);
endmodule

// File: rtl/qrss_gen.sv
module qrss_gen
    import qrss_pkg::*;
#(
    parameter int           SYNC_STAGES = 2,
    parameter int           MAX_ZEROS   = 14,
    parameter logic [19:0]  SEED        = 20'h00001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pat_sel,
    input  logic       uni_mode,
    input  logic       err_req,
    input  logic       bpv_req,
    output logic       tx_bit,
    output logic       tx_pos,
    output logic       tx_neg
);
    logic      en;
    logic      raw_bit;
    logic      jam;
    logic      err_pend;
    logic      bpv_pend;
    logic      err_use;
    logic      bpv_use;
    logic      sent_bit;
    line_sym_t sym;

    assign en       = sel_is_qrss(pat_sel);
    assign err_use  = en & err_pend & ~jam;
    assign sent_bit = jam | (raw_bit ^ err_use);
    assign bpv_use  = en & bpv_pend & sent_bit;

    qrss_lfsr #(
        .W    (LFSR_W),
        .T_HI (TAP_HI),
        .T_LO (TAP_LO),
        .SEED (SEED)
    ) u_lfsr (
        .clk (clk),
        .rst (rst),
        .adv (en),
        .msb (raw_bit)
    );

    qrss_zero_guard #(
        .MAX_ZEROS (MAX_ZEROS)
    ) u_guard (
        .clk      (clk),
        .rst      (rst),
        .adv      (en),
        .sent_bit (sent_bit),
        .jam      (jam)
    );

    qrss_req_sync #(
        .STAGES (SYNC_STAGES)
    ) u_err_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (err_req),
        .consume   (err_use),
        .pend      (err_pend)
    );

    qrss_req_sync #(
        .STAGES (SYNC_STAGES)
    ) u_bpv_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (bpv_req),
        .consume   (bpv_use),
        .pend      (bpv_pend)
    );

    qrss_ami_enc u_ami (
        .clk      (clk),
        .rst      (rst),
        .adv      (en),
        .mark     (sent_bit),
        .viol     (bpv_use),
        .uni_mode (uni_mode),
        .sym      (sym)
    );

    assign tx_bit = sym.data;
    assign tx_pos = sym.pos;
    assign tx_neg = sym.neg;

    // R1: outputs idle one clock after the source is turned off
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tx_bit && !tx_pos && !tx_neg);

    // R4: a forced position always leaves as a mark
    a_r4_forced_mark: assert property (@(posedge clk) disable iff (rst)
        (en && jam) |=> (tx_pos || tx_neg));

    // R6: an error meeting a forced bit stays pending
    a_r6_defer: assert property (@(posedge clk) disable iff (rst)
        (en && jam && err_pend) |=> err_pend);

    // R10: in rail-only mode the data pin stays low
    a_r10_rail_only: assert property (@(posedge clk) disable iff (rst)
        !uni_mode |=> !tx_bit);
endmodule

// File: tb/qrss_gen_tb_top.sv
module qrss_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] pat_sel;
    logic       uni_mode, err_req, bpv_req;
    logic       tx_bit, tx_pos, tx_neg;

    always #5 clk = ~clk;

    qrss_gen dut_i (
        .clk(clk), .rst(rst), .pat_sel(pat_sel), .uni_mode(uni_mode),
        .err_req(err_req), .bpv_req(bpv_req),
        .tx_bit(tx_bit), .tx_pos(tx_pos), .tx_neg(tx_neg)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model state, built from the requirements
    logic [19:0] m_lfsr;
    int          m_zc;
    logic        m_last, m_s1e, m_s2e, m_pe, m_pend_e, m_s1b, m_s2b, m_pb, m_pend_b;
    logic        m_bit, m_pos, m_neg, m_en_q;
    int          m_err_cnt = 0, m_bpv_cnt = 0, m_defer_cnt = 0;

    // rail observer
    logic        o_last = 1'b0;
    int          o_viol = 0;
    int          o_run  = 0;

    always @(posedge clk) begin
        logic rise_e, rise_b, en, jam, eu, bu, b, pol;
        if (rst) begin
            m_lfsr = 20'h00001; m_zc = 0; m_last = 1'b0;
            {m_s1e, m_s2e, m_pe, m_pend_e} = '0;
            {m_s1b, m_s2b, m_pb, m_pend_b} = '0;
            {m_bit, m_pos, m_neg, m_en_q} = '0;
        end else begin
            rise_e = m_s2e & ~m_pe;
            rise_b = m_s2b & ~m_pb;
            en = (pat_sel == 2'b10);
            eu = 1'b0; bu = 1'b0;
            if (en) begin
                jam = (m_zc == 14);
                if (jam && m_pend_e) m_defer_cnt++;
                eu  = m_pend_e & ~jam;
                b   = jam | (m_lfsr[19] ^ eu);
                bu  = m_pend_b & b;
                pol = bu ? m_last : ~m_last;
                m_bit = uni_mode & b;
                m_pos = b & pol;
                m_neg = b & ~pol;
                if (b) m_last = pol;
                m_lfsr = {m_lfsr[18:0], m_lfsr[19] ^ m_lfsr[16]};
                m_zc   = b ? 0 : m_zc + 1;
                if (eu) m_err_cnt++;
                if (bu) m_bpv_cnt++;
            end else begin
                {m_bit, m_pos, m_neg} = '0;
            end
            m_en_q   = en;
            m_pend_e = (m_pend_e & ~eu) | (rise_e & ~m_pend_e);
            m_pend_b = (m_pend_b & ~bu) | (rise_b & ~m_pend_b);
            m_pe = m_s2e; m_s2e = m_s1e; m_s1e = err_req;
            m_pb = m_s2b; m_s2b = m_s1b; m_s1b = bpv_req;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // called at a negedge: compare outputs and run the rail observer
    task automatic cmp(input string tag);
        chk(tag, "tx_bit", int'(tx_bit), int'(m_bit));
        chk(tag, "tx_pos", int'(tx_pos), int'(m_pos));
        chk(tag, "tx_neg", int'(tx_neg), int'(m_neg));
        if (tx_pos || tx_neg) begin
            if (tx_pos == o_last) o_viol++;
            o_last = tx_pos;
        end
        if (m_en_q) begin
            if (tx_pos || tx_neg) o_run = 0;
            else begin
                o_run++;
                if (o_run > 14) chk("R4", "zero run length", o_run, 14);
            end
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        cmp(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int e0, b0;
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);
        rst = 1'b1; pat_sel = 2'b10; uni_mode = 1'b1; err_req = 1'b0; bpv_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "tx_bit in reset", int'(tx_bit), 0);
        chk("R11", "tx_pos in reset", int'(tx_pos), 0);
        chk("R11", "tx_neg in reset", int'(tx_neg), 0);
        rst = 1'b0;

        // R3 / R4: the seed gives zeros first, so fourteen spaces then a forced mark
        for (int i = 0; i < 14; i++) begin
            step("R3");
            chk("R3", "leading space", int'(tx_bit), 0);
        end
        // R6: park at run count 14, request an error, resume on the forced bit
        pat_sel = 2'b00;
        err_req = 1'b1;
        step("R1");
        err_req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step("R1");
            chk("R1", "idle pos while off", int'(tx_pos), 0);
        end
        uni_mode = 1'b0;
        pat_sel  = 2'b10;
        step("R4");
        chk("R4", "forced mark on positive rail", int'(tx_pos), 1);
        step("R6");
        chk("R6", "deferred error mark on negative rail", int'(tx_neg), 1);
        chk("R10", "rail-only data pin", int'(tx_bit), 0);
        chk("R6", "deferral events", m_defer_cnt, 1);
        chk("R6", "errors applied", m_err_cnt, 1);

        // R7: held-high request gives one insertion
        uni_mode = 1'b1;
        e0 = m_err_cnt;
        err_req = 1'b1;
        for (int i = 0; i < 20; i++) step("R7");
        err_req = 1'b0;
        for (int i = 0; i < 6; i++) step("R7");
        chk("R7", "insertions from held request", m_err_cnt - e0, 1);

        // R7: second edge while first still pending (source off) is discarded
        pat_sel = 2'b01;
        b0 = m_bpv_cnt;
        bpv_req = 1'b1; step("R2"); bpv_req = 1'b0; step("R2");
        step("R2"); step("R2"); step("R2");
        bpv_req = 1'b1; step("R2"); bpv_req = 1'b0;
        for (int i = 0; i < 30; i++) step("R2");
        pat_sel = 2'b10;
        for (int i = 0; i < 60; i++) step("R2");
        chk("R7", "violations from two edges while pending", m_bpv_cnt - b0, 1);

        // R9: violation in unipolar mode and in bipolar mode
        uni_mode = 1'b1;
        b0 = m_bpv_cnt;
        bpv_req = 1'b1; step("R9"); bpv_req = 1'b0;
        for (int i = 0; i < 40; i++) step("R9");
        uni_mode = 1'b0;
        bpv_req = 1'b1; step("R9"); bpv_req = 1'b0;
        for (int i = 0; i < 40; i++) step("R9");
        chk("R9", "violations in both modes", m_bpv_cnt - b0, 2);
        chk("R8", "observed repeats vs requested", o_viol, m_bpv_cnt);

        // R5: single pulse while running
        e0 = m_err_cnt;
        err_req = 1'b1; step("R5"); err_req = 1'b0;
        for (int i = 0; i < 8; i++) step("R5");
        chk("R5", "single pulse insertion", m_err_cnt - e0, 1);

        // random mix
        for (int i = 0; i < 12000; i++) begin
            int unsigned r;
            r = $urandom;
            if (r[3:0] == 4'd0) pat_sel = 2'($urandom);
            else if (r[3:0] < 4'd4) pat_sel = 2'b10;
            if (r[11:4] == 8'd0) uni_mode = ~uni_mode;
            if (r[14:12] == 3'd0) err_req = ~err_req;
            if (r[17:15] == 3'd0) bpv_req = ~bpv_req;
            step("R3");
        end
        err_req = 1'b0; bpv_req = 1'b0; pat_sel = 2'b10;
        for (int i = 0; i < 200; i++) step("R8");
        chk("R8", "observed repeats vs requested at end", o_viol, m_bpv_cnt);

        // R11: reset mid-stream clears outputs
        rst = 1'b1;
        step("R11");
        chk("R11", "tx_pos after reset", int'(tx_pos), 0);
        rst = 1'b0;
        o_last = 1'b0; o_run = 0;
        for (int i = 0; i < 20; i++) step("R11");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule